// File: doc/BRIEF.md
# Bidirectional Latched Octal Transceiver

This block moves a byte between two ports, A and B, in either direction. Each direction has its own bank of level-sensitive storage, its own output gate and its own set of three active-low controls. The controls are a select that enables both the storage and the output, a hold control that freezes the storage, and a drive control that enables the output. A byte can be passed straight through to the far port, or parked in the bank and presented later while the near port changes.

Each port is kept as three separate signals: an input byte, an output byte and a one-bit drive flag. The core therefore needs no bidirectional pins. An outer level that owns the pads builds the tri-state buses from these signals. Storage is modelled with a clock: a bank takes in its input at every clock edge at which it is open. Between edges an open bank passes its input to the output through combinational logic. A flag reports any moment when the block drives both ports at once.

Top module: `oxcvr_core`

## Requirements
- R1: A synchronous active-low reset `rst_n` clears both banks to zero. After reset, a bank that is closed (select low, hold high) with its drive enabled presents 0x00.
- R2: While `ab_sel_n` and `ab_hold_n` are both low, the A-to-B bank is open. With `ab_drv_n` also low, `b_out` equals `a_in` in the same cycle, bit for bit and without inversion.
- R3: The A-to-B bank keeps the `a_in` value present at the last rising clock edge at which it was open. While `ab_hold_n` stays high it keeps that value, whatever `a_in` does.
- R4: While `ab_sel_n` is high, the A-to-B bank does not change, whatever `ab_hold_n` is, and `b_oe` is low whatever `ab_drv_n` is.
- R5: `b_oe` is high only when `ab_sel_n` and `ab_drv_n` are both low. Whenever `b_oe` is low, `b_out` is 0x00.
- R6: The B-to-A direction follows R2 to R5 with the ports swapped, under `ba_sel_n`, `ba_hold_n` and `ba_drv_n`. Its controls and data never affect the A-to-B bank or outputs, and the reverse also holds.
- R7: `both_drive` is high in exactly the cycles in which `a_oe` and `b_oe` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the banks take in data on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 8 | Byte arriving on port A |
| a_out | output | 8 | Byte driven onto port A (0 when not driving) |
| a_oe | output | 1 | High when port A is driven |
| b_in | input | 8 | Byte arriving on port B |
| b_out | output | 8 | Byte driven onto port B (0 when not driving) |
| b_oe | output | 1 | High when port B is driven |
| ab_sel_n | input | 1 | A-to-B select, active low |
| ab_hold_n | input | 1 | A-to-B hold control; low opens the bank |
| ab_drv_n | input | 1 | A-to-B output drive, active low |
| ba_sel_n | input | 1 | B-to-A select, active low |
| ba_hold_n | input | 1 | B-to-A hold control; low opens the bank |
| ba_drv_n | input | 1 | B-to-A output drive, active low |
| both_drive | output | 1 | High when both ports are driven at once |

## Verification
The assertions watch, on every cycle, the gating rules: output enables that follow select and drive, zero outputs when not driving, flow-through while open, unchanged outputs across consecutive closed cycles, and the contention flag. Only the bench scenarios can show which byte a bank actually kept. To do so they preload a bank, apply each of the eight control combinations with new data, and then read the bank back through a closed, driving output. The same scenarios show the reset value and that one direction leaves the other untouched, because they apply different control combinations to the two directions at the same time.

// File: rtl/oxcvr_pkg.sv
// Package: shared control type and decode helpers for the latched transceiver.
// Assumes all three direction controls are active low.
package oxcvr_pkg;

    typedef struct packed {
        logic sel_n;   // enables storage and output of one direction
        logic hold_n;  // low lets the bank follow its input
        logic drv_n;   // low lets the bank drive the far port
    } dir_ctrl_t;

    // Bank follows its input only when selected and not holding.
    function automatic logic is_open(input dir_ctrl_t c);
        return !c.sel_n && !c.hold_n;
    endfunction

    // Far port is driven only when selected and drive requested.
    function automatic logic is_driving(input dir_ctrl_t c);
        return !c.sel_n && !c.drv_n;
    endfunction

endpackage

// File: rtl/oxcvr_latch_bank.sv
// Module: one direction's storage bank, one storage bit per data bit.
// Models a level-sensitive latch with a clock: every edge at which the bank
// is open takes in the input, and between edges an open bank is combinationally
// transparent. A closed bank presents the value it last took in.
// Assumes a synchronous active-low reset that clears all bits.
module oxcvr_latch_bank #(
    parameter int WIDTH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [WIDTH-1:0]       d_in,
    input  oxcvr_pkg::dir_ctrl_t   ctrl,
    output logic [WIDTH-1:0]       q_view
);
    logic open_w;
    assign open_w = oxcvr_pkg::is_open(ctrl);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic held_q;

        // Capture the input bit while open; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                held_q <= 1'b0;
            else if (open_w)
                held_q <= d_in[i];
        end

        // Present the live input while open, the held bit otherwise.
        assign q_view[i] = open_w ? d_in[i] : held_q;
    end

endmodule

// File: rtl/oxcvr_driver.sv
// Module: output gate for one direction.
// Drives the bank view onto the far port when selected and enabled, else
// presents zero with the drive flag low. Purely combinational.
module oxcvr_driver #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]       view,
    input  oxcvr_pkg::dir_ctrl_t   ctrl,
    output logic [WIDTH-1:0]       port_out,
    output logic                   port_oe
);
    logic en_w;
    assign en_w = oxcvr_pkg::is_driving(ctrl);

    // Gate the data with the drive condition so an idle port reads zero.
    always_comb begin
        port_oe  = en_w;
        port_out = en_w ? view : '0;
    end

endmodule

// File: rtl/oxcvr_contention.sv
// Module: flags cycles in which the block drives both ports at once.
// Assumes the drive flags come straight from the two output gates.
module oxcvr_contention (
    input  logic a_drive,
    input  logic b_drive,
    output logic clash
);
    // Combinational overlap of the two drive flags.
    always_comb clash = a_drive && b_drive;

endmodule

// File: rtl/oxcvr_core.sv
// Module: bidirectional latched transceiver core with split port signals.
// Two fully independent directions, each a storage bank plus an output gate,
// and a contention detector across both drive flags. An outer level is
// expected to turn (in, out, oe) triples into tri-state buses.
module oxcvr_core #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic             ab_sel_n,
    input  logic             ab_hold_n,
    input  logic             ab_drv_n,
    input  logic             ba_sel_n,
    input  logic             ba_hold_n,
    input  logic             ba_drv_n,
    output logic             both_drive
);
    oxcvr_pkg::dir_ctrl_t ab_ctrl, ba_ctrl;
    logic [WIDTH-1:0]     ab_view, ba_view;

    // Bundle each direction's controls.
    always_comb begin
        ab_ctrl = '{sel_n: ab_sel_n, hold_n: ab_hold_n, drv_n: ab_drv_n};
        ba_ctrl = '{sel_n: ba_sel_n, hold_n: ba_hold_n, drv_n: ba_drv_n};
    end

    oxcvr_latch_bank #(.WIDTH(WIDTH)) ab_bank_i (
        .clk(clk), .rst_n(rst_n), .d_in(a_in), .ctrl(ab_ctrl), .q_view(ab_view)
    );

    oxcvr_latch_bank #(.WIDTH(WIDTH)) ba_bank_i (
        .clk(clk), .rst_n(rst_n), .d_in(b_in), .ctrl(ba_ctrl), .q_view(ba_view)
    );

    oxcvr_driver #(.WIDTH(WIDTH)) b_drv_i (
        .view(ab_view), .ctrl(ab_ctrl), .port_out(b_out), .port_oe(b_oe)
    );

    oxcvr_driver #(.WIDTH(WIDTH)) a_drv_i (
        .view(ba_view), .ctrl(ba_ctrl), .port_out(a_out), .port_oe(a_oe)
    );

    oxcvr_contention clash_i (
        .a_drive(a_oe), .b_drive(b_oe), .clash(both_drive)
    );

endmodule

// File: rtl/oxcvr_core_chk.sv
// Module: property checker for oxcvr_core, attached by bind below.
// Observes ports only; holds from reset release onward.
module oxcvr_core_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe,
    input logic             ab_sel_n,
    input logic             ab_hold_n,
    input logic             ab_drv_n,
    input logic             ba_sel_n,
    input logic             ba_hold_n,
    input logic             ba_drv_n,
    input logic             both_drive
);
    logic ab_closed_drv, ba_closed_drv;
    assign ab_closed_drv = !ab_sel_n && ab_hold_n && !ab_drv_n;
    assign ba_closed_drv = !ba_sel_n && ba_hold_n && !ba_drv_n;

    assert_ab_flow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_sel_n && !ab_hold_n && !ab_drv_n) |-> (b_out == a_in && b_oe));

    assert_ba_flow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_sel_n && !ba_hold_n && !ba_drv_n) |-> (a_out == b_in && a_oe));

    assert_ab_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_closed_drv && $past(ab_closed_drv) && $past(rst_n)) |-> $stable(b_out));

    assert_ba_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_closed_drv && $past(ba_closed_drv) && $past(rst_n)) |-> $stable(a_out));

    assert_ab_desel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ab_sel_n |-> !b_oe);

    assert_b_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_oe) |-> (b_out == '0));

    assert_b_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        b_oe |-> (!ab_sel_n && !ab_drv_n));

    assert_a_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_oe) |-> (a_out == '0));

    assert_clash_R7: assert property (@(posedge clk) disable iff (!rst_n)
        both_drive |-> (!ab_sel_n && !ab_drv_n && !ba_sel_n && !ba_drv_n));

    assert_clash_seen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe && b_oe) |-> both_drive);

endmodule

bind oxcvr_core oxcvr_core_chk #(.WIDTH(WIDTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_sel_n(ab_sel_n), .ab_hold_n(ab_hold_n), .ab_drv_n(ab_drv_n),
    .ba_sel_n(ba_sel_n), .ba_hold_n(ba_hold_n), .ba_drv_n(ba_drv_n),
    .both_drive(both_drive)
);

// File: tb/oxcvr_core_tb_top.sv
`timescale 1ns/1ps
module oxcvr_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] a_in, b_in, a_out, b_out;
    logic       a_oe, b_oe, both_drive;
    logic       ab_sel_n, ab_hold_n, ab_drv_n, ba_sel_n, ba_hold_n, ba_drv_n;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    oxcvr_core #(.WIDTH(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_sel_n(ab_sel_n), .ab_hold_n(ab_hold_n), .ab_drv_n(ab_drv_n),
        .ba_sel_n(ba_sel_n), .ba_hold_n(ba_hold_n), .ba_drv_n(ba_drv_n),
        .both_drive(both_drive)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Advance one clock; inputs change 1 ns after the rising edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_ab(input logic [2:0] c);
        {ab_sel_n, ab_hold_n, ab_drv_n} = c;
    endtask

    task automatic set_ba(input logic [2:0] c);
        {ba_sel_n, ba_hold_n, ba_drv_n} = c;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset with banks closed and driving, inputs busy.
        rst_n = 1'b0;
        set_ab(3'b010); set_ba(3'b010);
        a_in = 8'hA5; b_in = 8'h5A;
        tick(); tick();
        rst_n = 1'b1;
        #1;
        chk("R1 b_out after reset", b_out, 8'h00);
        chk("R1 a_out after reset", a_out, 8'h00);
        chk("R1 b_oe after reset", {7'd0, b_oe}, 8'h01);
        tick();

        // Sweep: every A-to-B control combo, B-to-A gets the complement combo.
        for (int k = 0; k < 16; k++) begin
            for (int c = 0; c < 8; c++) begin
                logic [7:0] p, q, d, e;
                logic [2:0] cb;
                logic ab_open, ab_drv, ba_open, ba_drv;
                p  = 8'((k * 37 + 5) & 255);
                q  = 8'((k * 91 + 200) & 255);
                d  = ~p ^ 8'(c * 17);
                e  = ~q ^ 8'(c * 29);
                cb = 3'(7 - c);
                ab_open = !c[2] && !c[1];
                ab_drv  = !c[2] && !c[0];
                ba_open = !cb[2] && !cb[1];
                ba_drv  = !cb[2] && !cb[0];

                // Preload both banks through the open, driving state.
                set_ab(3'b000); set_ba(3'b000);
                a_in = p; b_in = q;
                #1;
                chk("R2 flow-through a->b", b_out, p);
                chk("R6 flow-through b->a", a_out, q);
                chk("R7 both driving", {7'd0, both_drive}, 8'h01);
                tick();

                // Apply the combo with fresh data.
                set_ab(c[2:0]); set_ba(cb);
                a_in = d; b_in = e;
                #1;
                chk("R5 b_oe gating", {7'd0, b_oe}, {7'd0, ab_drv});
                chk("R2 R4 R5 b_out", b_out, ab_drv ? (ab_open ? d : p) : 8'h00);
                chk("R6 a_oe gating", {7'd0, a_oe}, {7'd0, ba_drv});
                chk("R6 a_out", a_out, ba_drv ? (ba_open ? e : q) : 8'h00);
                chk("R7 contention", {7'd0, both_drive}, {7'd0, ab_drv && ba_drv});
                tick();

                // Read back through closed, driving banks for two cycles.
                set_ab(3'b010); set_ba(3'b010);
                a_in = ~d; b_in = ~e;
                #1;
                chk("R3 R4 kept a->b", b_out, ab_open ? d : p);
                chk("R6 kept b->a", a_out, ba_open ? e : q);
                tick();
                a_in = 8'h00; b_in = 8'hFF;
                #1;
                chk("R3 still held a->b", b_out, ab_open ? d : p);
                chk("R6 still held b->a", a_out, ba_open ? e : q);
                tick();
            end
        end

        // R1: reset mid-run clears stored bytes.
        set_ab(3'b000); set_ba(3'b000);
        a_in = 8'h3C; b_in = 8'hC3;
        tick();
        set_ab(3'b010); set_ba(3'b010);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        #1;
        chk("R1 mid-run reset b_out", b_out, 8'h00);
        chk("R1 mid-run reset a_out", a_out, 8'h00);

        // R4: deselected with hold low over several edges keeps content.
        set_ab(3'b000); a_in = 8'h81;
        tick();
        set_ab(3'b100); a_in = 8'h7E;
        tick(); tick();
        set_ab(3'b010);
        #1;
        chk("R4 deselect keeps bank", b_out, 8'h81);
        tick();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule